// File: doc/BRIEF.md
# Aliased Miscellaneous Control Register with Level Interrupt

This block holds one 64-bit control and status word behind a simple register strobe (valid, write, address, byte count, data). Software reaches the word through three neighbouring offsets. The first offset replaces the word or reads it. The second offset combines the write data with the stored word. The third offset sets the bits that are high in the write data. A build-time generation selector picks the base offset. It also picks the meaning of the combining alias: an AND on the older generation, or an unconditional clear on the newer one.

Only the top 19 bits of the word are kept. The bits are numbered from the most significant end, so bit 0 is data[63], and bits 0 to 18 are data[63:45]. Stored bit 0 drives a level interrupt towards the platform interrupt controller. An on-chip agent can post a message by pulsing a request line. The request raises the interrupt bit and the shared-memory bit together, and leaves every other bit as it was. Any access whose byte count is not 8 is refused.

Top module: `misc_reg_ctrl`

## Requirements
- R1: After a synchronous reset the stored word is zero and `irq` is low.
- R2: Only data[63:45] (bits 0..18 counted from the MSB) are stored. Every other bit of the stored word and of the read data is zero after any write.
- R3: A write to the base offset (0x4020 when GEN_NEWER=0, 0x6080 when GEN_NEWER=1) replaces the word with the masked data. A read of the base offset returns the stored word one cycle after the strobe, with `rd_valid` high for that one cycle.
- R4: With GEN_NEWER=0, a write to base+1 stores the old word ANDed with the write data.
- R5: With GEN_NEWER=1, a write to base+1 clears the whole word, whatever the write data.
- R6: A write to base+2 stores the old word ORed with the masked write data.
- R7: `irq` is high exactly while stored bit 0 (data[63]) is set.
- R8: A pulse on `msg_req` sets data[63] and data[60] (bits 0 and 3) and keeps the other bits.
- R9: When a bus write and `msg_req` occur in the same cycle, the bus result is formed first and the two message bits are ORed onto it.
- R10: A read of any other offset returns zero with `rd_valid`. A write to any other offset leaves the word unchanged.
- R11: An access with `bus_bytes` other than 8 is refused. A refused write changes nothing. A refused read returns zero with `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_bytes | input | 4 | Access width in bytes |
| bus_wdata | input | 64 | Write data |
| msg_req | input | 1 | Internal message post, one cycle per event |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |
| irq | output | 1 | Level interrupt from stored bit 0 |

## Verification
Writes and message posts update the stored word on the clock edge that samples them. `irq` therefore follows the new value after that same edge. Read data and `rd_valid` are registered, so they appear one cycle after the read strobe and hold the word as it was before that edge. The bench drives every stimulus on a falling edge and samples at the next falling edge. It compares against a model that has already stepped across the single edge in between. Both generations are instantiated side by side on one shared bus, so the same random mix of aliases, foreign offsets, bad widths and message posts exercises the AND variant and the clear variant at once.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;

    localparam int WORD_W    = 64;
    localparam int BYTES_W   = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_AND,
        OP_CLEAR,
        OP_OR
    } wr_op_e;

    typedef struct packed {
        logic   rd;        // any read strobe, answered with rd_valid
        logic   rd_hit;    // read that returns the stored word
        wr_op_e op;        // write action on the stored word
    } dec_t;

    // Mask keeping n bits counted from the MSB.
    function automatic logic [WORD_W-1:0] top_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) m[WORD_W-1-i] = 1'b1;
        end
        return m;
    endfunction

    // Single bit counted from the MSB.
    function automatic logic [WORD_W-1:0] msb0_bit(input int idx);
        logic [WORD_W-1:0] m;
        m = '0;
        m[WORD_W-1-idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/misc_reg_decode.sv
module misc_reg_decode
    import misc_reg_pkg::*;
#(
    parameter bit GEN_NEWER = 1'b0,
    parameter int ADDR_W    = 16,
    parameter int ACC_BYTES = 8
) (
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BYTES_W-1:0] bus_bytes,
    output dec_t               dec
);
    localparam logic [ADDR_W-1:0] BASE_OFF  = GEN_NEWER ? ADDR_W'(16'h6080) : ADDR_W'(16'h4020);
    localparam logic [ADDR_W-1:0] COMB_OFF  = BASE_OFF + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SET_OFF   = BASE_OFF + ADDR_W'(2);

    wr_op_e comb_op;
    logic   size_ok;

    generate
        if (GEN_NEWER) begin : g_clear_alias
            assign comb_op = OP_CLEAR;
        end else begin : g_and_alias
            assign comb_op = OP_AND;
        end
    endgenerate

    assign size_ok = (bus_bytes == BYTES_W'(ACC_BYTES));

    always_comb begin
        dec        = '{rd: 1'b0, rd_hit: 1'b0, op: OP_NONE};
        if (bus_valid) begin
            if (!bus_write) begin
                dec.rd     = 1'b1;
                dec.rd_hit = size_ok && (bus_addr == BASE_OFF);
            end else if (size_ok) begin
                unique case (bus_addr)
                    BASE_OFF: dec.op = OP_LOAD;
                    COMB_OFF: dec.op = comb_op;
                    SET_OFF:  dec.op = OP_OR;
                    default:  dec.op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/misc_reg_update.sv
module misc_reg_update
    import misc_reg_pkg::*;
#(
    parameter int KEEP_BITS = 19,
    parameter int IRQ_BIT   = 0,
    parameter int SHM_BIT   = 3
) (
    input  logic [WORD_W-1:0] cur,
    input  wr_op_e            op,
    input  logic [WORD_W-1:0] wdata,
    input  logic              msg_req,
    output logic [WORD_W-1:0] nxt
);
    localparam logic [WORD_W-1:0] KEEP = top_mask(KEEP_BITS);
    localparam logic [WORD_W-1:0] MSG  = msb0_bit(IRQ_BIT) | msb0_bit(SHM_BIT);

    logic [WORD_W-1:0] bus_res;

    always_comb begin
        unique case (op)
            OP_LOAD:  bus_res = wdata;
            OP_AND:   bus_res = cur & wdata;
            OP_CLEAR: bus_res = '0;
            OP_OR:    bus_res = cur | wdata;
            default:  bus_res = cur;
        endcase
        nxt = (bus_res | (msg_req ? MSG : '0)) & KEEP;
    end

endmodule

// File: rtl/misc_reg_readback.sv
module misc_reg_readback
    import misc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              rd_hit,
    input  logic [WORD_W-1:0] cur,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            rd_data  <= rd_hit ? cur : '0;
        end
    end

    a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_valid);
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rd_valid);
    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && !rd_hit) |=> (rd_data == '0));

endmodule

// File: rtl/misc_reg_ctrl.sv
module misc_reg_ctrl
    import misc_reg_pkg::*;
#(
    parameter bit GEN_NEWER = 1'b0,
    parameter int ADDR_W    = 16,
    parameter int KEEP_BITS = 19,
    parameter int IRQ_BIT   = 0,
    parameter int SHM_BIT   = 3,
    parameter int ACC_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_bytes,
    input  logic [63:0]        bus_wdata,
    input  logic               msg_req,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic               irq
);
    localparam logic [WORD_W-1:0] KEEP = top_mask(KEEP_BITS);
    localparam int IRQ_POS = WORD_W - 1 - IRQ_BIT;
    localparam int SHM_POS = WORD_W - 1 - SHM_BIT;

    dec_t              dec;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    misc_reg_decode #(
        .GEN_NEWER (GEN_NEWER),
        .ADDR_W    (ADDR_W),
        .ACC_BYTES (ACC_BYTES)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_bytes (bus_bytes),
        .dec       (dec)
    );

    misc_reg_update #(
        .KEEP_BITS (KEEP_BITS),
        .IRQ_BIT   (IRQ_BIT),
        .SHM_BIT   (SHM_BIT)
    ) u_update (
        .cur     (word_q),
        .op      (dec.op),
        .wdata   (bus_wdata),
        .msg_req (msg_req),
        .nxt     (word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    misc_reg_readback u_readback (
        .clk      (clk),
        .rst      (rst),
        .rd       (dec.rd),
        .rd_hit   (dec.rd_hit),
        .cur      (word_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign irq = word_q[IRQ_POS];

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (word_q == '0) && !irq);
    a_r2_masked_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & ~KEEP) == '0));
    a_r8_msg_raises: assert property (@(posedge clk) disable iff (rst)
        msg_req |=> irq && word_q[SHM_POS]);
    a_r6_set_keeps: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_OR) |=> ((word_q & $past(word_q)) == $past(word_q)));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_NONE && !msg_req) |=> $stable(word_q));

    generate
        if (GEN_NEWER) begin : g_chk_clear
            a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
                (dec.op == OP_CLEAR && !msg_req) |=> (word_q == '0));
        end else begin : g_chk_and
            a_r4_and_shrinks: assert property (@(posedge clk) disable iff (rst)
                (dec.op == OP_AND && !msg_req) |=> ((word_q & ~$past(word_q)) == '0));
        end
    endgenerate

endmodule

// File: tb/misc_reg_ctrl_tb.sv
module misc_reg_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam logic [63:0] KEEP = {{19{1'b1}}, {45{1'b0}}};
    localparam logic [63:0] MSGB = 64'h9000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr  = '0;
    logic [3:0]  bus_bytes = 4'd8;
    logic [63:0] bus_wdata = '0;
    logic        msg_req   = 1'b0;

    logic        rv_o, rv_n, irq_o, irq_n;
    logic [63:0] rd_o, rd_n;

    int checks = 0;
    int fails  = 0;
    logic [63:0] m_o = '0;
    logic [63:0] m_n = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    misc_reg_ctrl #(.GEN_NEWER(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .msg_req(msg_req), .rd_valid(rv_o), .rd_data(rd_o), .irq(irq_o));

    misc_reg_ctrl #(.GEN_NEWER(1'b1)) u_dut_new (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .msg_req(msg_req), .rd_valid(rv_n), .rd_data(rd_n), .irq(irq_n));

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Next stored value from the requirements (R2..R11)
    function automatic logic [63:0] model_next(input bit newer, input logic [63:0] cur,
        input bit v, input bit w, input logic [15:0] a, input logic [3:0] b,
        input logic [63:0] d, input bit m);
        logic [15:0] base;
        logic [63:0] r;
        base = newer ? 16'h6080 : 16'h4020;
        r = cur;
        if (v && w && b == 4'd8) begin
            if (a == base)                  r = d;
            else if (a == base + 16'd1)     r = newer ? 64'd0 : (cur & d);
            else if (a == base + 16'd2)     r = cur | d;
        end
        if (m) r = r | MSGB;
        return r & KEEP;
    endfunction

    function automatic logic [63:0] model_read(input bit newer, input logic [63:0] cur,
        input logic [15:0] a, input logic [3:0] b);
        logic [15:0] base;
        base = newer ? 16'h6080 : 16'h4020;
        return (b == 4'd8 && a == base) ? cur : 64'd0;
    endfunction

    // One bus cycle; called right after a falling edge, ends after the next one.
    task automatic step(input bit v, input bit w, input logic [15:0] a,
                        input logic [3:0] b, input logic [63:0] d, input bit m,
                        input string tag);
        logic [63:0] er_o, er_n;
        bit erv;
        bus_valid = v; bus_write = w; bus_addr = a; bus_bytes = b;
        bus_wdata = d; msg_req = m;
        erv  = v && !w;
        er_o = model_read(1'b0, m_o, a, b);
        er_n = model_read(1'b1, m_n, a, b);
        m_o  = model_next(1'b0, m_o, v, w, a, b, d, m);
        m_n  = model_next(1'b1, m_n, v, w, a, b, d, m);
        @(negedge clk);
        bus_valid = 1'b0; msg_req = 1'b0;
        check(rv_o == erv, {tag, " R3 rd_valid old"}, 64'(rv_o), 64'(erv));
        check(rv_n == erv, {tag, " R3 rd_valid new"}, 64'(rv_n), 64'(erv));
        if (erv) begin
            check(rd_o == er_o, {tag, " R10 R11 rd_data old"}, rd_o, er_o);
            check(rd_n == er_n, {tag, " R10 R11 rd_data new"}, rd_n, er_n);
        end
        check(irq_o == m_o[63], {tag, " R7 irq old"}, 64'(irq_o), 64'(m_o[63]));
        check(irq_n == m_n[63], {tag, " R7 irq new"}, 64'(irq_n), 64'(m_n[63]));
    endtask

    task automatic rd_both(input string tag);
        step(1, 0, 16'h4020, 4'd8, '0, 0, tag);
        step(1, 0, 16'h6080, 4'd8, '0, 0, tag);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(irq_o == 0 && irq_n == 0 && rv_o == 0 && rv_n == 0, "R1 reset outputs",
              {irq_o, irq_n, rv_o, rv_n}, 64'd0);
        rd_both("R1 reset read");
        // R2/R3: full-ones write keeps only top 19 bits
        step(1, 1, 16'h4020, 4'd8, '1, 0, "R2 load old");
        step(1, 1, 16'h6080, 4'd8, '1, 0, "R2 load new");
        rd_both("R2 masked readback");
        // R4: AND alias on old; R5: clear alias on new
        step(1, 1, 16'h4021, 4'd8, 64'hF0F0_0000_0000_0000, 0, "R4 and");
        step(1, 1, 16'h6081, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5 clear");
        rd_both("R4 R5 readback");
        // R6: OR alias
        step(1, 1, 16'h4022, 4'd8, 64'h0A00_0000_0000_0000, 0, "R6 or old");
        step(1, 1, 16'h6082, 4'd8, 64'h0000_7000_0000_0000, 0, "R6 or new");
        rd_both("R6 readback");
        // R8: message post
        step(0, 0, 16'h0, 4'd8, '0, 1, "R8 msg");
        rd_both("R8 readback");
        // R9: write with message in the same cycle
        step(1, 1, 16'h4020, 4'd8, 64'h0100_0000_0000_0000, 1, "R9 load+msg old");
        step(1, 1, 16'h6081, 4'd8, '0, 1, "R9 clear+msg new");
        rd_both("R9 readback");
        // R10: foreign offset write and read
        step(1, 1, 16'h4023, 4'd8, '0, 0, "R10 foreign write");
        step(1, 0, 16'h4023, 4'd8, '0, 0, "R10 foreign read");
        rd_both("R10 readback");
        // R11: wrong width write and read
        step(1, 1, 16'h4020, 4'd4, '0, 0, "R11 narrow write old");
        step(1, 1, 16'h6081, 4'd1, '0, 0, "R11 narrow clear new");
        step(1, 0, 16'h4020, 4'd4, '0, 0, "R11 narrow read");
        rd_both("R11 readback");
        // R7: clearing bit 0 drops irq
        step(1, 1, 16'h4020, 4'd8, '0, 0, "R7 irq drop old");
        step(1, 1, 16'h6080, 4'd8, '0, 0, "R7 irq drop new");
        // Random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [15:0] a;
            logic [3:0]  b;
            logic [63:0] d;
            case ($urandom_range(0, 7))
                0: a = 16'h4020; 1: a = 16'h4021; 2: a = 16'h4022;
                3: a = 16'h6080; 4: a = 16'h6081; 5: a = 16'h6082;
                6: a = 16'h4023; default: a = 16'($urandom);
            endcase
            b = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'd8;
            d = {$urandom, $urandom};
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, b, d,
                 $urandom_range(0, 5) == 0, "random");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule